// File: doc/BRIEF.md
# Interrupt Signalling Priority Filter

This block is the per-core decision stage that sits between a set of interrupt sources and a processor's two interrupt request lines. Each of the sources arrives with its pending, active and enable bits, a group bit, a Security bit for group 1 and an 8-bit priority. The block picks the most urgent eligible source. It reports that source on a highest-pending output, and then decides whether to raise the normal request line (IRQ) or the fast request line (FIQ) for it.

The highest-pending report always shows the winner, even when nothing is raised, so software can see why an interrupt is not reaching the core. Signalling then depends on four things: the priority mask, the running priority of the interrupt being serviced, the enable for the winner's group at both the core and the distributor level, and how the winner's group relates to the current Security state. Acknowledge, end-of-interrupt and distribution between cores are handled elsewhere.

Top module: `irq_sig_filter`

## Requirements
- R1: A source is a candidate only when its `pend_i` bit is 1, its `act_i` bit is 0 and its `en_i` bit is 1. A source that is active, pending or not, is never reported or signalled.
- R2: The highest-pending output names the candidate with the numerically lowest priority. Among equal priorities the lowest ID wins. With no candidate it shows `hpp_valid_o`=0, `hpp_id_o`=0 and `hpp_prio_o`=0xFF.
- R3: The highest-pending output does not depend on the priority mask, the running priority or any group enable.
- R4: The winner is signalled only if its priority is strictly lower than `pmr_i`. A priority equal to the mask, or a priority of 0xFF, is never signalled.
- R5: The winner is signalled only if its priority is strictly lower than `rpr_i`. The idle running priority is 0xFF.
- R6: A winner with `grp_i`=0 (group 0) is signalled on `fiq_o`.
- R7: A winner with `grp_i`=1 is signalled on `irq_o` when its `gsec_i` bit (1 = Secure) equals `cur_sec_i` (1 = Secure), and on `fiq_o` otherwise.
- R8: A winner is signalled only when its class is enabled at both levels. Group 0 needs `core_en_g0_i` and `dist_en_g0_i`. Secure group 1 needs `core_en_g1s_i` and `dist_en_g1s_i`. Non-secure group 1 needs `core_en_g1ns_i` and `dist_en_g1ns_i`.
- R9: Only the winner is considered for signalling. If the winner is blocked, nothing is raised, even when a less urgent candidate would pass.
- R10: All outputs are registered and reflect the inputs present at the previous rising clock edge. While `rst_ni` is low they hold 0, except `hpp_prio_o`, which holds 0xFF.
- R11: `irq_o` and `fiq_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_INT | Pending bit per source |
| act_i | input | NUM_INT | Active bit per source |
| en_i | input | NUM_INT | Enable bit per source |
| grp_i | input | NUM_INT | Group per source: 0 = group 0, 1 = group 1 |
| gsec_i | input | NUM_INT | Security of a group 1 source: 1 = Secure |
| prio_i | input | NUM_INT*PRIO_W | Priority of source i in bits [i*PRIO_W +: PRIO_W] |
| pmr_i | input | PRIO_W | Priority mask |
| rpr_i | input | PRIO_W | Running priority, all ones when idle |
| cur_sec_i | input | 1 | Current Security state: 1 = Secure |
| core_en_g0_i | input | 1 | Core-level enable, group 0 |
| core_en_g1s_i | input | 1 | Core-level enable, Secure group 1 |
| core_en_g1ns_i | input | 1 | Core-level enable, Non-secure group 1 |
| dist_en_g0_i | input | 1 | Distributor-level enable, group 0 |
| dist_en_g1s_i | input | 1 | Distributor-level enable, Secure group 1 |
| dist_en_g1ns_i | input | 1 | Distributor-level enable, Non-secure group 1 |
| hpp_valid_o | output | 1 | A candidate exists |
| hpp_id_o | output | ID_W | ID of the best candidate |
| hpp_prio_o | output | PRIO_W | Priority of the best candidate |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Every output is due exactly one rising edge after the inputs that produce it, because all five outputs come from a single register stage. The bench changes inputs on the falling edge and samples on the following falling edge, so each check sees the result of exactly one capture. A directed test also reads the request line just after an input change and before the next rising edge, to confirm that it has not moved early. A reset test confirms that the outputs clear as soon as reset is asserted, without waiting for a clock edge.

// File: rtl/irq_filt_pkg.sv
package irq_filt_pkg;
  typedef enum logic [1:0] {
    SIG_NONE = 2'd0,
    SIG_IRQ  = 2'd1,
    SIG_FIQ  = 2'd2
  } sig_e;

  // doubles as index into the per-class enable vectors
  typedef enum logic [1:0] {
    CLS_G0   = 2'd0,
    CLS_G1S  = 2'd1,
    CLS_G1NS = 2'd2
  } grp_cls_e;
endpackage

// File: rtl/irq_filt_arb.sv
module irq_filt_arb #(
  parameter int NUM_INT = 16,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 4
) (
  input  logic [NUM_INT-1:0]        cand_i,
  input  logic [NUM_INT*PRIO_W-1:0] prio_i,
  output logic                      valid_o,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o
);
  localparam int NLEAF = 1 << ID_W;
  localparam int NNODE = 2 * NLEAF - 1;

  logic              nv [NNODE];
  logic [ID_W-1:0]   nid[NNODE];
  logic [PRIO_W-1:0] np [NNODE];

  for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
    if (i < NUM_INT) begin : g_real
      assign nv[NLEAF-1+i] = cand_i[i];
      assign np[NLEAF-1+i] = prio_i[i*PRIO_W +: PRIO_W];
    end else begin : g_pad
      assign nv[NLEAF-1+i] = 1'b0;
      assign np[NLEAF-1+i] = '1;
    end
    assign nid[NLEAF-1+i] = ID_W'(i);
  end

  // heap-ordered tournament; left child holds lower IDs, so ties go left
  for (genvar k = 0; k < NLEAF - 1; k++) begin : g_node
    logic take_l;
    assign take_l = nv[2*k+1] && (!nv[2*k+2] || (np[2*k+1] <= np[2*k+2]));
    assign nv[k]  = nv[2*k+1] | nv[2*k+2];
    assign nid[k] = take_l ? nid[2*k+1] : nid[2*k+2];
    assign np[k]  = take_l ? np[2*k+1]  : np[2*k+2];
  end

  assign valid_o = nv[0];
  assign id_o    = nv[0] ? nid[0] : '0;
  assign prio_o  = nv[0] ? np[0]  : '1;
endmodule

// File: rtl/irq_filt_gate.sv
module irq_filt_gate
  import irq_filt_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              best_v_i,
  input  logic [PRIO_W-1:0] best_prio_i,
  input  logic              best_grp_i,
  input  logic              best_gsec_i,
  input  logic              cur_sec_i,
  input  logic [PRIO_W-1:0] pmr_i,
  input  logic [PRIO_W-1:0] rpr_i,
  input  logic [2:0]        core_en_i,
  input  logic [2:0]        dist_en_i,
  output grp_cls_e          cls_o,
  output sig_e              sig_o
);
  logic prio_ok;
  logic grp_on;

  always_comb begin
    if (!best_grp_i)      cls_o = CLS_G0;
    else if (best_gsec_i) cls_o = CLS_G1S;
    else                  cls_o = CLS_G1NS;
  end

  assign prio_ok = (best_prio_i < pmr_i) && (best_prio_i < rpr_i);
  assign grp_on  = core_en_i[cls_o] & dist_en_i[cls_o];

  always_comb begin
    sig_o = SIG_NONE;
    if (best_v_i && prio_ok && grp_on) begin
      if (cls_o == CLS_G0)                 sig_o = SIG_FIQ;
      else if (best_gsec_i == cur_sec_i)   sig_o = SIG_IRQ;
      else                                 sig_o = SIG_FIQ;
    end
  end
endmodule

// File: rtl/irq_sig_filter.sv
module irq_sig_filter
  import irq_filt_pkg::*;
#(
  parameter  int NUM_INT = 16,
  parameter  int PRIO_W  = 8,
  localparam int ID_W    = (NUM_INT > 1) ? $clog2(NUM_INT) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_INT-1:0]        pend_i,
  input  logic [NUM_INT-1:0]        act_i,
  input  logic [NUM_INT-1:0]        en_i,
  input  logic [NUM_INT-1:0]        grp_i,
  input  logic [NUM_INT-1:0]        gsec_i,
  input  logic [NUM_INT*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         pmr_i,
  input  logic [PRIO_W-1:0]         rpr_i,
  input  logic                      cur_sec_i,
  input  logic                      core_en_g0_i,
  input  logic                      core_en_g1s_i,
  input  logic                      core_en_g1ns_i,
  input  logic                      dist_en_g0_i,
  input  logic                      dist_en_g1s_i,
  input  logic                      dist_en_g1ns_i,
  output logic                      hpp_valid_o,
  output logic [ID_W-1:0]           hpp_id_o,
  output logic [PRIO_W-1:0]         hpp_prio_o,
  output logic                      irq_o,
  output logic                      fiq_o
);
  logic [NUM_INT-1:0] cand;
  logic               best_v;
  logic [ID_W-1:0]    best_id;
  logic [PRIO_W-1:0]  best_p;
  logic               best_grp;
  logic               best_gsec;
  grp_cls_e           cls;
  sig_e               sig_d;

  assign cand = pend_i & ~act_i & en_i;

  irq_filt_arb #(
    .NUM_INT(NUM_INT),
    .PRIO_W (PRIO_W),
    .ID_W   (ID_W)
  ) u_arb (
    .cand_i (cand),
    .prio_i (prio_i),
    .valid_o(best_v),
    .id_o   (best_id),
    .prio_o (best_p)
  );

  assign best_grp  = grp_i[best_id];
  assign best_gsec = gsec_i[best_id];

  irq_filt_gate #(
    .PRIO_W(PRIO_W)
  ) u_gate (
    .best_v_i   (best_v),
    .best_prio_i(best_p),
    .best_grp_i (best_grp),
    .best_gsec_i(best_gsec),
    .cur_sec_i  (cur_sec_i),
    .pmr_i      (pmr_i),
    .rpr_i      (rpr_i),
    .core_en_i  ({core_en_g1ns_i, core_en_g1s_i, core_en_g0_i}),
    .dist_en_i  ({dist_en_g1ns_i, dist_en_g1s_i, dist_en_g0_i}),
    .cls_o      (cls),
    .sig_o      (sig_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hpp_valid_o <= 1'b0;
      hpp_id_o    <= '0;
      hpp_prio_o  <= '1;
      irq_o       <= 1'b0;
      fiq_o       <= 1'b0;
    end else begin
      hpp_valid_o <= best_v;
      hpp_id_o    <= best_id;
      hpp_prio_o  <= best_p;
      irq_o       <= (sig_d == SIG_IRQ);
      fiq_o       <= (sig_d == SIG_FIQ);
    end
  end

  // ---------------- assertions ----------------
  p_cand_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    best_v |-> (pend_i[best_id] && !act_i[best_id] && en_i[best_id]));

  p_none_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~act_i & en_i) == '0) |-> !best_v);

  for (genvar i = 0; i < NUM_INT; i++) begin : g_chk
    p_best_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[i] && !act_i[i] && en_i[i]) |->
        (best_v && ((best_p < prio_i[i*PRIO_W +: PRIO_W]) ||
                    ((best_p == prio_i[i*PRIO_W +: PRIO_W]) && (best_id <= ID_W'(i))))));
  end

  p_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || fiq_o) |-> ($past(best_p) < $past(pmr_i)));

  p_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || fiq_o) |-> ($past(best_p) < $past(rpr_i)));

  p_g0_fiq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_d != SIG_NONE && !grp_i[best_id]) |-> (sig_d == SIG_FIQ));

  p_g1_route_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_d != SIG_NONE && grp_i[best_id]) |->
      ((sig_d == SIG_IRQ) == (gsec_i[best_id] == cur_sec_i)));

  p_g0_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_d != SIG_NONE && cls == CLS_G0) |-> (core_en_g0_i && dist_en_g0_i));

  p_lat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_d == SIG_IRQ) |=> irq_o);

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && fiq_o));
endmodule

// File: tb/tb_irq_sig_filter.sv
module tb_irq_sig_filter;
  localparam int N = 16;
  localparam int W = 8;

  typedef struct packed {
    logic [15:0] pend;
    logic [15:0] act;
    logic [15:0] en;
    logic [15:0] grp;
    logic [15:0] gsec;
    logic [7:0]  pmr;
    logic [7:0]  rpr;
    logic        cur;
    logic [5:0]  gen;  // {dist g1ns, dist g1s, dist g0, core g1ns, core g1s, core g0}
    logic        ev;
    logic [3:0]  eid;
    logic        eirq;
    logic        efiq;
  } vec_t;

  // default priority map: source i has ((i>>1)<<5), so pairs tie
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{16'h0000,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'hFF,1'b0,6'h3F,1'b0,4'd0, 1'b0,1'b0}, // R2 none
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'hFF,1'b0,6'h3F,1'b1,4'd3, 1'b1,1'b0}, // R7 NS g1 in NS
    '{16'h0008,16'h0000,16'hFFFF,16'h0000,16'h0000,8'hFF,8'hFF,1'b0,6'h3F,1'b1,4'd3, 1'b0,1'b1}, // R6 g0
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'hFFFF,8'hFF,8'hFF,1'b0,6'h3F,1'b1,4'd3, 1'b0,1'b1}, // R7 other state
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'hFFFF,8'hFF,8'hFF,1'b1,6'h3F,1'b1,4'd3, 1'b1,1'b0}, // R7 S g1 in S
    '{16'h000C,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'hFF,1'b0,6'h3F,1'b1,4'd2, 1'b1,1'b0}, // R2 tie
    '{16'h8001,16'h0001,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'hFF,1'b0,6'h3F,1'b1,4'd15,1'b1,1'b0}, // R1 active skipped
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'h20,8'hFF,1'b0,6'h3F,1'b1,4'd3, 1'b0,1'b0}, // R4 equal mask, R3
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'h21,8'hFF,1'b0,6'h3F,1'b1,4'd3, 1'b1,1'b0}, // R4 pass
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'h20,1'b0,6'h3F,1'b1,4'd3, 1'b0,1'b0}, // R5 equal running, R3
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'h21,1'b0,6'h3F,1'b1,4'd3, 1'b1,1'b0}, // R5 preempts
    '{16'h0003,16'h0000,16'hFFFE,16'hFFFF,16'h0000,8'hFF,8'hFF,1'b0,6'h3F,1'b1,4'd1, 1'b1,1'b0}, // R1 disabled skipped
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'hFF,1'b0,6'h3B,1'b1,4'd3, 1'b0,1'b0}, // R8 core g1ns off, R3
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'hFF,1'b0,6'h1F,1'b1,4'd3, 1'b0,1'b0}, // R8 dist g1ns off
    '{16'h0009,16'h0000,16'hFFFF,16'h0008,16'h0000,8'hFF,8'hFF,1'b0,6'h3E,1'b1,4'd0, 1'b0,1'b0}, // R9 blocked winner
    '{16'h0001,16'h0000,16'hFFFF,16'h0000,16'h0000,8'hFF,8'hFF,1'b0,6'h09,1'b1,4'd0, 1'b0,1'b1}, // R8 only g0 on
    '{16'h0008,16'h0008,16'hFFFF,16'hFFFF,16'h0000,8'hFF,8'hFF,1'b0,6'h3F,1'b0,4'd0, 1'b0,1'b0}, // R1 active+pending
    '{16'h0008,16'h0000,16'hFFFF,16'hFFFF,16'hFFFF,8'hFF,8'hFF,1'b1,6'h3D,1'b1,4'd3, 1'b0,1'b0}  // R8 core g1s off
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     pend, act, en, grp, gsec;
  logic [N*W-1:0]   prio;
  logic [W-1:0]     pmr, rpr;
  logic             cur;
  logic             cg0, cg1s, cg1ns, dg0, dg1s, dg1ns;
  logic             hv, irq, fiq;
  logic [3:0]       hid;
  logic [W-1:0]     hp;
  int               n_chk = 0;
  int               n_fail = 0;

  always #5 clk = ~clk;

  irq_sig_filter #(.NUM_INT(N), .PRIO_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pend_i(pend), .act_i(act), .en_i(en), .grp_i(grp), .gsec_i(gsec),
    .prio_i(prio), .pmr_i(pmr), .rpr_i(rpr), .cur_sec_i(cur),
    .core_en_g0_i(cg0), .core_en_g1s_i(cg1s), .core_en_g1ns_i(cg1ns),
    .dist_en_g0_i(dg0), .dist_en_g1s_i(dg1s), .dist_en_g1ns_i(dg1ns),
    .hpp_valid_o(hv), .hpp_id_o(hid), .hpp_prio_o(hp),
    .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [7:0] pmap(int i);
    return 8'((i >> 1) << 5);
  endfunction

  task automatic set_default_prio();
    for (int i = 0; i < N; i++) prio[i*W +: W] = pmap(i);
  endtask

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic apply(vec_t v);
    pend = v.pend; act = v.act; en = v.en; grp = v.grp; gsec = v.gsec;
    pmr = v.pmr; rpr = v.rpr; cur = v.cur;
    {dg1ns, dg1s, dg0, cg1ns, cg1s, cg0} = v.gen;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    set_default_prio();
    apply(VECS[1]);
    // R10 reset state while a signalable source is present
    repeat (3) @(negedge clk);
    chk("R10", "reset hv", 32'(hv), 32'd0);
    chk("R10", "reset hid", 32'(hid), 32'd0);
    chk("R10", "reset hp", 32'(hp), 32'hFF);
    chk("R10", "reset irq", 32'(irq), 32'd0);
    chk("R10", "reset fiq", 32'(fiq), 32'd0);
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(VECS[k]);
      @(posedge clk);
      @(negedge clk);
      chk("R2", $sformatf("v%0d hpp valid", k), 32'(hv), 32'(VECS[k].ev));
      chk("R2", $sformatf("v%0d hpp id", k), 32'(hid), 32'(VECS[k].ev ? VECS[k].eid : 4'd0));
      chk("R2", $sformatf("v%0d hpp prio", k), 32'(hp),
          32'(VECS[k].ev ? pmap(int'(VECS[k].eid)) : 8'hFF));
      chk("R6/R7", $sformatf("v%0d irq", k), 32'(irq), 32'(VECS[k].eirq));
      chk("R6/R7", $sformatf("v%0d fiq", k), 32'(fiq), 32'(VECS[k].efiq));
      chk("R11", $sformatf("v%0d exclusive", k), 32'(irq & fiq), 32'd0);
    end

    // R10 latency: nothing moves before the capturing edge
    @(negedge clk);
    apply(VECS[0]);
    @(negedge clk);
    apply(VECS[1]);
    #1;
    chk("R10", "irq before edge", 32'(irq), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "irq after one edge", 32'(irq), 32'd1);

    // R4 priority 0xFF is reported but never signalled
    prio[3*W +: W] = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    chk("R4", "prio FF hp", 32'(hp), 32'hFF);
    chk("R4", "prio FF hv", 32'(hv), 32'd1);
    chk("R4", "prio FF irq", 32'(irq), 32'd0);
    set_default_prio();

    // R3 highest-pending unaffected by mask, running priority and enables
    pmr = 8'h00; rpr = 8'h00;
    {dg1ns, dg1s, dg0, cg1ns, cg1s, cg0} = 6'h00;
    @(posedge clk);
    @(negedge clk);
    chk("R3", "blocked hid", 32'(hid), 32'd3);
    chk("R3", "blocked hp", 32'(hp), 32'h20);
    chk("R3", "blocked irq", 32'(irq), 32'd0);

    // R10 asynchronous reset clears at once
    apply(VECS[1]);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "pre-reset irq", 32'(irq), 32'd1);
    #2 rst_n = 1'b0;
    #1;
    chk("R10", "async reset irq", 32'(irq), 32'd0);
    chk("R10", "async reset hp", 32'(hp), 32'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule